// File: doc/BRIEF.md
# Extended-Format Target Address Generator

This block sits between instruction fetch and operand fetch of a 24-bit word machine with a one-megabyte byte address space. It takes up to four instruction bytes, the program counter (already advanced past the instruction), and the low 20 bits of the base and index registers. From these it reports the instruction length, an addressing-kind code and the 20-bit target address. Register-only instructions (one and two bytes) produce no address. For two-byte instructions it also returns the two register numbers.

Memory-reference instructions carry the flags n and i in the two low bits of the first byte. The second byte carries x, b, p and e in bits 7 to 4. Together these flags select one of four address forms: base-relative, PC-relative, 20-bit absolute, or a 15-bit legacy field. On top of that, the operand is read as immediate, simple or indirect. For indirect operands, a two-state controller issues one memory read at the computed address and reports the low 20 bits of the returned word as the final target.

The controller has two states:
- IDLE: the block waits for `start`.
- FETCH: one indirect read is outstanding.

Its transitions are:
- IDLE to FETCH, when `start` arrives with a legal indirect instruction.
- IDLE to IDLE, when `start` arrives with any other instruction. `done` pulses in the next cycle.
- FETCH to IDLE, when `mem_vld` is sampled high. `done` pulses in the next cycle.

Top module: `tgt_addr_unit`

## Requirements
- R1: First bytes C0, C4, C8, F0, F4, F8 (hex) are one-byte register instructions. They give length 1, kind 0, target 0 and no memory request.
- R2: First bytes 90, 94, 98, 9C, A0, A4, A8, AC, B0, B4, B8 are two-byte instructions. They give length 2 and kind 0. `reg1` is bits 7:4 of byte 1 and `reg2` is bits 3:0.
- R3: For any other first byte with n,i not both 0, the length is 3 when e=0 and 4 when e=1.
- R4: With e=0, b=1, p=0, the target is the base plus the 12-bit displacement, zero-extended, modulo 2^20. The displacement is bits 3:0 of byte 1 followed by byte 2.
- R5: With e=0, b=0, p=1, the target is the PC plus the sign-extended displacement, modulo 2^20.
- R6: With e=0, b=p=0, the target is the displacement. With e=1, the target is the 20-bit field formed by bits 3:0 of byte 1, byte 2 and byte 3.
- R7: When x=1 (bit 7 of byte 1), the index is added to the target modulo 2^20 in every memory-reference form.
- R8: With n=i=0, the length is 3, the kind is simple, and the target is the 15-bit field formed by bits 6:0 of byte 1 and byte 2 (plus the index when x=1).
- R9: The kind code is 0 for register instructions, 1 for immediate (n=0,i=1), 2 for simple (n=i=1 or n=i=0) and 3 for indirect (n=1,i=0).
- R10: `bad_flags` rises, the target is 0 and no memory request is made when n,i are not both 0 and either (e=0, b=1, p=1) or (e=1 with b or p set).
- R11: For a legal indirect instruction, `mem_req` rises in the cycle after `start`, with `mem_addr` set to the computed address. Both hold until `mem_vld` is sampled. In the next cycle `mem_req` is low, `done` is high and `tgt` equals the low 20 bits of `mem_rdata`.
- R12: For all other instructions, `done` is a one-cycle pulse in the cycle after `start`. While `busy` is high, `start` is ignored.
- R13: After reset, `done`, `mem_req`, `busy`, `bad_flags`, `ins_len`, `akind` and `tgt` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Instruction bytes are valid; sampled in IDLE |
| ins_b0 | input | 8 | First instruction byte (opcode, n, i) |
| ins_b1 | input | 8 | Second byte (x, b, p, e, displacement high) |
| ins_b2 | input | 8 | Third byte |
| ins_b3 | input | 8 | Fourth byte (extended form only) |
| pc_in | input | 20 | Program counter after the instruction |
| base_in | input | 20 | Low 20 bits of the base register |
| index_in | input | 20 | Low 20 bits of the index register |
| mem_vld | input | 1 | Read response valid |
| mem_rdata | input | 24 | Read response word |
| busy | output | 1 | Indirect fetch outstanding |
| done | output | 1 | Result valid pulse |
| ins_len | output | 3 | Instruction length in bytes |
| akind | output | 2 | Addressing kind code |
| bad_flags | output | 1 | Illegal b/p/e combination |
| tgt | output | 20 | Target address or immediate operand |
| reg1 | output | 4 | First register number (two-byte form) |
| reg2 | output | 4 | Second register number (two-byte form) |
| mem_req | output | 1 | Indirect read request |
| mem_addr | output | 20 | Indirect read address |

## Verification
A decode fault shows up as a wrong `ins_len`, `akind` or `tgt` on the `done` cycle, one cycle after `start`. A controller stuck in FETCH shows up differently: `done` never rises, `busy` stays high, and the next `start` has no effect. A controller that leaves FETCH without a response drops `mem_req` early. It then reports a `tgt` that does not match the returned word, within one cycle of the fault. Randomised flag patterns are mixed with directed wrap-around and illegal-flag cases, so each address form is seen both with and without indexing.

// File: rtl/tau_pkg.sv
package tau_pkg;

    typedef enum logic [1:0] {
        AK_REG    = 2'd0,
        AK_IMM    = 2'd1,
        AK_SIMPLE = 2'd2,
        AK_IND    = 2'd3
    } akind_t;

    function automatic logic is_one_byte(input logic [7:0] op);
        unique case (op)
            8'hC0, 8'hC4, 8'hC8, 8'hF0, 8'hF4, 8'hF8: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic is_two_byte(input logic [7:0] op);
        unique case (op)
            8'h90, 8'h94, 8'h98, 8'h9C, 8'hA0, 8'hA4,
            8'hA8, 8'hAC, 8'hB0, 8'hB4, 8'hB8: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tau_decode.sv
module tau_decode
    import tau_pkg::*;
(
    input  logic [7:0] b0,
    input  logic [7:0] b1,
    output logic [2:0] len,
    output akind_t     kind,
    output logic       legacy,
    output logic       err,
    output logic [3:0] r1,
    output logic [3:0] r2
);

    logic fb, fp, fe;

    assign fb = b1[6];
    assign fp = b1[5];
    assign fe = b1[4];
    assign r1 = b1[7:4];
    assign r2 = b1[3:0];

    always_comb begin
        len    = 3'd0;
        kind   = AK_REG;
        legacy = 1'b0;
        err    = 1'b0;
        if (is_one_byte(b0)) begin
            len = 3'd1;
        end else if (is_two_byte(b0)) begin
            len = 3'd2;
        end else begin
            unique case (b0[1:0])
                2'b00: begin
                    kind   = AK_SIMPLE;
                    legacy = 1'b1;
                end
                2'b01: kind = AK_IMM;
                2'b10: kind = AK_IND;
                2'b11: kind = AK_SIMPLE;
            endcase
            if (legacy) begin
                len = 3'd3;
            end else begin
                len = fe ? 3'd4 : 3'd3;
                err = fe ? (fb | fp) : (fb & fp);
            end
        end
    end

endmodule

// File: rtl/tau_ea.sv
module tau_ea #(
    parameter int AW    = 20,
    parameter int DW    = 12,
    parameter int LEG_W = 15
) (
    input  logic [7:0]    b1,
    input  logic [7:0]    b2,
    input  logic [7:0]    b3,
    input  logic          legacy,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] index,
    output logic [AW-1:0] ta
);

    logic             fx, fb, fp, fe;
    logic [DW-1:0]    disp;
    logic [LEG_W-1:0] leg;
    logic [AW-1:0]    ext_field;
    logic [AW-1:0]    disp_u;
    logic [AW-1:0]    disp_s;
    logic [AW-1:0]    raw;

    assign fx        = b1[7];
    assign fb        = b1[6];
    assign fp        = b1[5];
    assign fe        = b1[4];
    assign disp      = {b1[3:0], b2};
    assign leg       = {b1[6:0], b2};
    assign ext_field = {b1[3:0], b2, b3};
    assign disp_u    = {{(AW-DW){1'b0}}, disp};
    assign disp_s    = {{(AW-DW){disp[DW-1]}}, disp};

    always_comb begin
        if (legacy)
            raw = {{(AW-LEG_W){1'b0}}, leg};
        else if (fe)
            raw = ext_field;
        else if (fb && !fp)
            raw = base + disp_u;
        else if (fp && !fb)
            raw = pc + disp_s;
        else
            raw = disp_u;
        ta = raw + (fx ? index : '0);
    end

endmodule

// File: rtl/tau_ctrl.sv
module tau_ctrl
    import tau_pkg::*;
#(
    parameter int AW = 20,
    parameter int WW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    len_d,
    input  akind_t        kind_d,
    input  logic          err_d,
    input  logic [AW-1:0] ta_d,
    input  logic [3:0]    r1_d,
    input  logic [3:0]    r2_d,
    input  logic          mem_vld,
    input  logic [WW-1:0] mem_data,
    output logic          busy,
    output logic          done,
    output logic [2:0]    len_q,
    output akind_t        kind_q,
    output logic          err_q,
    output logic [AW-1:0] tgt_q,
    output logic [3:0]    r1_q,
    output logic [3:0]    r2_q,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr
);

    typedef enum logic {ST_IDLE, ST_FETCH} state_t;

    state_t state, nxt;
    logic   go_ind;
    logic   unused_hi;

    assign go_ind    = (kind_d == AK_IND) && !err_d;
    assign unused_hi = ^mem_data[WW-1:AW];
    assign busy      = (state == ST_FETCH);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start && go_ind) nxt = ST_FETCH;
            ST_FETCH: if (mem_vld) nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done     <= 1'b0;
            len_q    <= '0;
            kind_q   <= AK_REG;
            err_q    <= 1'b0;
            tgt_q    <= '0;
            r1_q     <= '0;
            r2_q     <= '0;
            mem_req  <= 1'b0;
            mem_addr <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        len_q  <= len_d;
                        kind_q <= kind_d;
                        err_q  <= err_d;
                        r1_q   <= r1_d;
                        r2_q   <= r2_d;
                        if (go_ind) begin
                            mem_req  <= 1'b1;
                            mem_addr <= ta_d;
                            tgt_q    <= '0;
                        end else begin
                            done  <= 1'b1;
                            tgt_q <= (err_d || kind_d == AK_REG) ? '0 : ta_d;
                        end
                    end
                end
                ST_FETCH: begin
                    if (mem_vld) begin
                        mem_req <= 1'b0;
                        tgt_q   <= mem_data[AW-1:0];
                        done    <= 1'b1;
                    end
                end
            endcase
        end
    end

    // R11: request and its address hold until a response arrives
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_vld |=> mem_req && $stable(mem_addr));

    // R11: a response ends the request and reports done
    p_vld_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_vld |=> done && !mem_req);

    // R11: done never overlaps an outstanding request
    p_req_done_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !done);

    // R12: a start taken in idle produces done or a request next cycle
    p_start_resp_r12: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> done || mem_req);

    // R10: an illegal flag set never leaves a request outstanding
    p_err_noreq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done && err_q |-> !mem_req && tgt_q == '0);

endmodule

// File: rtl/tgt_addr_unit.sv
module tgt_addr_unit
    import tau_pkg::*;
#(
    parameter int AW = 20,
    parameter int WW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    ins_b0,
    input  logic [7:0]    ins_b1,
    input  logic [7:0]    ins_b2,
    input  logic [7:0]    ins_b3,
    input  logic [AW-1:0] pc_in,
    input  logic [AW-1:0] base_in,
    input  logic [AW-1:0] index_in,
    input  logic          mem_vld,
    input  logic [WW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic [2:0]    ins_len,
    output logic [1:0]    akind,
    output logic          bad_flags,
    output logic [AW-1:0] tgt,
    output logic [3:0]    reg1,
    output logic [3:0]    reg2,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr
);

    logic [2:0]    len_d;
    akind_t        kind_d, kind_q;
    logic          legacy_d, err_d;
    logic [3:0]    r1_d, r2_d;
    logic [AW-1:0] ta_d;

    tau_decode u_dec (
        .b0     (ins_b0),
        .b1     (ins_b1),
        .len    (len_d),
        .kind   (kind_d),
        .legacy (legacy_d),
        .err    (err_d),
        .r1     (r1_d),
        .r2     (r2_d)
    );

    tau_ea #(.AW(AW)) u_ea (
        .b1     (ins_b1),
        .b2     (ins_b2),
        .b3     (ins_b3),
        .legacy (legacy_d),
        .pc     (pc_in),
        .base   (base_in),
        .index  (index_in),
        .ta     (ta_d)
    );

    tau_ctrl #(.AW(AW), .WW(WW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .len_d    (len_d),
        .kind_d   (kind_d),
        .err_d    (err_d),
        .ta_d     (ta_d),
        .r1_d     (r1_d),
        .r2_d     (r2_d),
        .mem_vld  (mem_vld),
        .mem_data (mem_rdata),
        .busy     (busy),
        .done     (done),
        .len_q    (ins_len),
        .kind_q   (kind_q),
        .err_q    (bad_flags),
        .tgt_q    (tgt),
        .r1_q     (reg1),
        .r2_q     (reg2),
        .mem_req  (mem_req),
        .mem_addr (mem_addr)
    );

    assign akind = kind_q;

    // R3: a reported length is always 1 to 4 bytes
    p_len_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ins_len >= 3'd1 && ins_len <= 3'd4);

    // R9: register-format lengths report kind 0, memory forms never do
    p_kind_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((ins_len <= 3'd2) == (akind == 2'd0)));

    // R12: busy implies an outstanding request
    p_busy_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> mem_req);

endmodule

// File: tb/sim_tgt_addr_unit.sv
`timescale 1ns/1ps
module sim_tgt_addr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  b0 = '0, b1 = '0, b2 = '0, b3 = '0;
    logic [19:0] pc = '0, bs = '0, ix = '0;
    logic        mem_vld = 1'b0;
    logic [23:0] mem_rdata = '0;
    logic        busy, done, bad_flags, mem_req;
    logic [2:0]  ins_len;
    logic [1:0]  akind;
    logic [19:0] tgt, mem_addr;
    logic [3:0]  reg1, reg2;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tgt_addr_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ins_b0(b0), .ins_b1(b1), .ins_b2(b2), .ins_b3(b3),
        .pc_in(pc), .base_in(bs), .index_in(ix),
        .mem_vld(mem_vld), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .ins_len(ins_len), .akind(akind),
        .bad_flags(bad_flags), .tgt(tgt), .reg1(reg1), .reg2(reg2),
        .mem_req(mem_req), .mem_addr(mem_addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic one_b(input logic [7:0] op);
        return op inside {8'hC0, 8'hC4, 8'hC8, 8'hF0, 8'hF4, 8'hF8};
    endfunction

    function automatic logic two_b(input logic [7:0] op);
        return op inside {8'h90, 8'h94, 8'h98, 8'h9C, 8'hA0, 8'hA4,
                          8'hA8, 8'hAC, 8'hB0, 8'hB4, 8'hB8};
    endfunction

    function automatic void model(output logic [2:0] l, output logic [1:0] k,
                                  output logic e_, output logic [19:0] t);
        logic [11:0] d;
        logic [19:0] raw;
        d   = {b1[3:0], b2};
        e_  = 1'b0;
        t   = '0;
        if (one_b(b0)) begin
            l = 3'd1; k = 2'd0;
        end else if (two_b(b0)) begin
            l = 3'd2; k = 2'd0;
        end else if (b0[1:0] == 2'b00) begin
            l = 3'd3; k = 2'd2;
            t = {5'd0, b1[6:0], b2} + (b1[7] ? ix : 20'd0);
        end else begin
            l  = b1[4] ? 3'd4 : 3'd3;
            k  = (b0[1:0] == 2'b01) ? 2'd1 : (b0[1:0] == 2'b10) ? 2'd3 : 2'd2;
            e_ = b1[4] ? (b1[6] | b1[5]) : (b1[6] & b1[5]);
            if (b1[4])                 raw = {b1[3:0], b2, b3};
            else if (b1[6] && !b1[5])  raw = bs + {8'd0, d};
            else if (b1[5] && !b1[6])  raw = pc + {{8{d[11]}}, d};
            else                       raw = {8'd0, d};
            t = e_ ? 20'd0 : raw + (b1[7] ? ix : 20'd0);
        end
    endfunction

    task automatic run_one(input string tag, input int lat, input logic poke);
        logic [2:0]  el;
        logic [1:0]  ek;
        logic        ee;
        logic [19:0] et;
        logic [7:0]  sb1;
        logic [23:0] rd;
        model(el, ek, ee, et);
        sb1 = b1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (ek == 2'd3 && !ee) begin
            check({tag, " R11 req"}, {31'd0, mem_req}, 32'd1);
            check({tag, " R11 addr"}, {12'd0, mem_addr}, {12'd0, et});
            check({tag, " R11 nodone"}, {31'd0, done}, 32'd0);
            for (int c = 0; c < lat; c++) begin
                if (poke) begin
                    b0 = 8'hC4;
                    start = 1'b1;
                end
                @(negedge clk);
                start = 1'b0;
                check({tag, " R11 hold"}, {12'd0, mem_addr}, {12'd0, et});
                check({tag, " R12 busy"}, {31'd0, busy}, 32'd1);
            end
            rd = $urandom;
            mem_rdata = rd;
            mem_vld = 1'b1;
            @(negedge clk) mem_vld = 1'b0;
            check({tag, " R11 done"}, {31'd0, done}, 32'd1);
            check({tag, " R11 tgt"}, {12'd0, tgt}, {12'd0, rd[19:0]});
            check({tag, " R11 reqlow"}, {31'd0, mem_req}, 32'd0);
            check({tag, " R12 kind kept"}, {30'd0, akind}, 32'd3);
            check({tag, " R3 len"}, {29'd0, ins_len}, {29'd0, el});
        end else begin
            check({tag, " R12 done"}, {31'd0, done}, 32'd1);
            check({tag, " R10 noreq"}, {31'd0, mem_req}, 32'd0);
            check({tag, " R3 len"}, {29'd0, ins_len}, {29'd0, el});
            check({tag, " R9 kind"}, {30'd0, akind}, {30'd0, ek});
            check({tag, " R10 err"}, {31'd0, bad_flags}, {31'd0, ee});
            check({tag, " R7 tgt"}, {12'd0, tgt}, {12'd0, et});
            if (el == 3'd2)
                check({tag, " R2 regs"}, {24'd0, reg1, reg2}, {24'd0, sb1});
            @(negedge clk);
            check({tag, " R12 pulse"}, {31'd0, done}, 32'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        repeat (3) @(negedge clk);
        // R13 reset state
        check("R13 done", {31'd0, done}, 32'd0);
        check("R13 req", {31'd0, mem_req}, 32'd0);
        check("R13 busy", {31'd0, busy}, 32'd0);
        check("R13 outs", {8'd0, bad_flags, ins_len, akind, tgt}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 one-byte
        b0 = 8'hC4; b1 = 8'hFF; b2 = 8'h12;
        run_one("R1 fix", 0, 1'b0);
        // R2 two-byte register fields
        b0 = 8'hA0; b1 = 8'h15;
        run_one("R2 cmp", 0, 1'b0);
        // R5 PC-relative negative displacement wraps below zero
        pc = 20'h00010; b0 = 8'h03; b1 = 8'h28; b2 = 8'h00;
        run_one("R5 neg", 0, 1'b0);
        // R4 base-relative max displacement wraps above top
        bs = 20'hFFFFF; b0 = 8'h03; b1 = 8'h4F; b2 = 8'hFF;
        run_one("R4 wrap", 0, 1'b0);
        // R6 extended absolute with R7 index
        ix = 20'h00123; b0 = 8'h4B; b1 = 8'h9A; b2 = 8'hBC; b3 = 8'hDE;
        run_one("R6 ext", 0, 1'b0);
        // R8 legacy 15-bit with index
        b0 = 8'h00; b1 = 8'hFF; b2 = 8'hFF;
        run_one("R8 legacy", 0, 1'b0);
        // R9 immediate
        b0 = 8'h01; b1 = 8'h00; b2 = 8'h05;
        run_one("R9 imm", 0, 1'b0);
        // R10 illegal flags, format 3 and format 4
        b0 = 8'h02; b1 = 8'h60;
        run_one("R10 bp", 0, 1'b0);
        b0 = 8'h4B; b1 = 8'h30; b3 = 8'h00;
        run_one("R10 ext", 0, 1'b0);
        // R11 indirect with zero and long latency, start ignored while busy
        b0 = 8'h02; b1 = 8'h20; b2 = 8'h40;
        run_one("R11 lat0", 0, 1'b0);
        b0 = 8'h02; b1 = 8'h40; b2 = 8'h40;
        run_one("R11 lat3", 3, 1'b1);

        for (int n = 0; n < 400; n++) begin
            if ($urandom % 6 == 0)
                b0 = ($urandom % 2) ? 8'hF0 + 8'($urandom % 3) * 8'd4
                                    : 8'h90 + 8'($urandom % 11) * 8'd4;
            else
                b0 = 8'($urandom);
            b1 = 8'($urandom); b2 = 8'($urandom); b3 = 8'($urandom);
            pc = 20'($urandom); bs = 20'($urandom); ix = 20'($urandom);
            run_one("rand", $urandom % 4, 1'($urandom % 2));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule